// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block controls 32 general-purpose pins through a small 32-bit register bus. Each pin can be an input or an output, and each output can be push-pull or open-drain. Every pin watches its synchronised input for edges. Software picks, per pin, whether only falling edges count or both edges count. A detected edge sets a sticky event bit. Software clears event bits by writing ones to them. A per-pin enable mask selects which pending events drive the single interrupt line, which is high while any enabled event is pending.

Registers sit at byte offsets 0x00 (direction), 0x04 (open-drain), 0x08 (data), 0x0C (event), 0x10 (enable mask) and 0x14 (trigger select). Bits are numbered MSB-first: pin n owns bit 31−n of every register. The pin-side ports `pin_in`, `pin_out` and `pin_oe` are indexed by pin number, so pin n is element n of those vectors. Software brings the block up by writing all ones to the event register and zero to the enable mask.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0. No pin drives, so `pin_oe` is 0, and `irq` is 0.
- R2: Pin n is controlled and reported by bit 31−n of every register, while the pin ports use index n.
- R3: A direction bit of 1 makes the pin an output. A read of the data register (0x08) returns the written data bit for output pins and the synchronised input level for input pins.
- R4: An output pin with its open-drain bit at 0 drives its data bit with `pin_oe` high. With open-drain at 1, a data bit of 0 drives low with `pin_oe` high, and a data bit of 1 releases the pin (`pin_oe` low). An input pin never has `pin_oe` high.
- R5: A change on `pin_in` that is stable before rising clock edge k sets the event bit, and `irq` if the pin is enabled, at rising edge k+2, and not earlier.
- R6: A trigger-select bit (0x14) of 1 captures only falling edges on that pin. A bit of 0 captures both rising and falling edges.
- R7: Writing the event register (0x0C) clears each bit written as 1 and leaves each bit written as 0 unchanged. Event bits never drop otherwise.
- R8: An edge detected in the same cycle as a write-one-to-clear of its event bit leaves that bit set.
- R9: `irq` is high exactly when the event register AND the enable mask (0x10, 1 = enabled) is non-zero. Events latch while masked and raise `irq` in the cycle after their pin is enabled.
- R10: A read strobed at a rising edge presents its value on `bus_rdata` from that edge until the next read. Offsets 0x18 and 0x1C read as 0.
- R11: Writing all ones to the event register clears every pending event at once, and `irq` drops after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register (bits 1:0 ignored) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin input levels, index = pin number |
| pin_out | output | 32 | Pin output values, index = pin number |
| pin_oe | output | 32 | Pin output enables, index = pin number |
| irq | output | 1 | Level interrupt |

## Verification
Register writes take effect at the rising edge where the strobe is sampled. Read data is due one edge after the strobe. An edge on a pin reaches the event register, and `irq`, on the third rising edge after the pin changes. The bench drives every stimulus on a falling edge and counts falling edges from there. It checks `irq` both one falling edge early and on time, to pin down the latency. A monitor pops the expected read values from a queue only on the falling edge after each read strobe. The coincident-clear case places the clear write on exactly the edge where the detected edge arrives.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    // Word indices (byte offset / 4) of the register file.
    localparam int unsigned WIDX_DIR   = 0;
    localparam int unsigned WIDX_OPEN  = 1;
    localparam int unsigned WIDX_DATA  = 2;
    localparam int unsigned WIDX_EVT   = 3;
    localparam int unsigned WIDX_MASK  = 4;
    localparam int unsigned WIDX_TRIG  = 5;

    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_OPEN = 3'd1,
        SEL_DATA = 3'd2,
        SEL_EVT  = 3'd3,
        SEL_MASK = 3'd4,
        SEL_TRIG = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,       // pin order
    input  logic [NPIN-1:0] fall_only,    // register order
    output logic [NPIN-1:0] lvl,          // register order, synchronised
    output logic [NPIN-1:0] hit           // register order, edge seen this cycle
);
    logic [NPIN-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        localparam int unsigned B = NPIN - 1 - p;
        logic rise, fall;
        always_comb begin
            rise   = sync_q[p] & ~prev_q[p];
            fall   = ~sync_q[p] & prev_q[p];
            lvl[B] = sync_q[p];
            hit[B] = fall | (rise & ~fall_only[B]);
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned NPIN = 32,
    parameter int unsigned AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [NPIN-1:0] bus_wdata,
    input  logic            bus_rd,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] lvl,
    input  logic [NPIN-1:0] hit,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] open_q,
    output logic [NPIN-1:0] dout_q,
    output logic [NPIN-1:0] evt_q,
    output logic [NPIN-1:0] mask_q,
    output logic [NPIN-1:0] trig_q,
    output logic            irq
);
    localparam int unsigned IW = AW - 2;

    reg_sel_e        sel;
    logic [NPIN-1:0] clr, evt_d, rd_val;
    logic [1:0]      unused_lo;

    assign unused_lo = bus_addr[1:0];

    always_comb begin
        unique case (bus_addr[AW-1:2])
            IW'(WIDX_DIR):  sel = SEL_DIR;
            IW'(WIDX_OPEN): sel = SEL_OPEN;
            IW'(WIDX_DATA): sel = SEL_DATA;
            IW'(WIDX_EVT):  sel = SEL_EVT;
            IW'(WIDX_MASK): sel = SEL_MASK;
            IW'(WIDX_TRIG): sel = SEL_TRIG;
            default:        sel = SEL_NONE;
        endcase
    end

    // New edges win over a simultaneous clear.
    always_comb begin
        clr   = (bus_wr && sel == SEL_EVT) ? bus_wdata : '0;
        evt_d = (evt_q & ~clr) | hit;
    end

    always_comb begin
        unique case (sel)
            SEL_DIR:  rd_val = dir_q;
            SEL_OPEN: rd_val = open_q;
            SEL_DATA: rd_val = (dir_q & dout_q) | (~dir_q & lvl);
            SEL_EVT:  rd_val = evt_q;
            SEL_MASK: rd_val = mask_q;
            SEL_TRIG: rd_val = trig_q;
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            open_q    <= '0;
            dout_q    <= '0;
            evt_q     <= '0;
            mask_q    <= '0;
            trig_q    <= '0;
            bus_rdata <= '0;
        end else begin
            evt_q <= evt_d;
            if (bus_wr) begin
                unique case (sel)
                    SEL_DIR:  dir_q  <= bus_wdata;
                    SEL_OPEN: open_q <= bus_wdata;
                    SEL_DATA: dout_q <= bus_wdata;
                    SEL_MASK: mask_q <= bus_wdata;
                    SEL_TRIG: trig_q <= bus_wdata;
                    default:  ;
                endcase
            end
            if (bus_rd) bus_rdata <= rd_val;
        end
    end

    assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int unsigned NPIN = 32
) (
    input  logic [NPIN-1:0] dir_q,     // register order
    input  logic [NPIN-1:0] open_q,
    input  logic [NPIN-1:0] dout_q,
    output logic [NPIN-1:0] pin_out,   // pin order
    output logic [NPIN-1:0] pin_oe
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pad
        localparam int unsigned B = NPIN - 1 - p;
        assign pin_out[p] = dout_q[B] & ~open_q[B];
        assign pin_oe[p]  = dir_q[B] & ~(open_q[B] & dout_q[B]);
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
    parameter int unsigned NPIN = 32,
    parameter int unsigned AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [NPIN-1:0] bus_wdata,
    input  logic            bus_rd,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq
);
    logic [NPIN-1:0] lvl_w, hit_w, dir_w, open_w, dout_w, evt_w, mask_w, trig_w;

    gpio_in_sync #(.NPIN(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .fall_only(trig_w),
        .lvl(lvl_w), .hit(hit_w)
    );

    gpio_regs #(.NPIN(NPIN), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .lvl(lvl_w), .hit(hit_w), .dir_q(dir_w), .open_q(open_w),
        .dout_q(dout_w), .evt_q(evt_w), .mask_q(mask_w), .trig_q(trig_w),
        .irq(irq)
    );

    gpio_pad_drive #(.NPIN(NPIN)) u_pad (
        .dir_q(dir_w), .open_q(open_w), .dout_q(dout_w),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
    parameter int unsigned NPIN = 32,
    parameter int unsigned AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic [NPIN-1:0] bus_wdata,
    input logic [NPIN-1:0] hit,
    input logic [NPIN-1:0] lvl,
    input logic [NPIN-1:0] evt,
    input logic [NPIN-1:0] mask,
    input logic [NPIN-1:0] trig,
    input logic [NPIN-1:0] dir,
    input logic [NPIN-1:0] pin_oe,
    input logic            irq
);
    logic            evt_wr;
    logic [NPIN-1:0] oe_reg;

    assign evt_wr = bus_wr && (bus_addr[AW-1:2] == (AW-2)'(3));

    always_comb begin
        for (int p = 0; p < NPIN; p++) oe_reg[NPIN-1-p] = pin_oe[p];
    end

    // R7
    evt_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr |=> ((evt & $past(bus_wdata & ~hit)) == '0));

    // R7
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_wr |=> (($past(evt) & ~evt) == '0));

    // R8
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> (($past(hit) & ~evt) == '0));

    // R6
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & trig & lvl) == '0));

    // R4
    in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe_reg & ~dir) == '0));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((evt != '0) && (mask != '0)));
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .hit(hit_w), .lvl(lvl_w), .evt(evt_w),
    .mask(mask_w), .trig(trig_w), .dir(dir_w), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;
    localparam logic [4:0] A_DIR = 5'h00, A_OPEN = 5'h04, A_DATA = 5'h08,
                           A_EVT = 5'h0C, A_MASK = 5'h10, A_TRIG = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
    logic        irq;

    always #2 clk = ~clk;

    gpio_edge_ctrl u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    int          n_cmp = 0, n_bad = 0;
    bit          finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_fire = 1'b0;

    function automatic logic [31:0] bitof(input int p);
        return 32'h8000_0000 >> p;
    endfunction

    // Scoreboard monitor: read data is due one edge after the strobe.
    always @(posedge clk) rd_fire <= bus_rd;
    always @(negedge clk) begin
        if (rd_fire) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R10: unexpected read data %h, expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = '0; pin_in = '0;
        idle(3);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 oe", pin_oe, 32'd0);
        rst_n = 1'b1;
        idle(1);
        // R1 reset values
        rd(A_DIR,  32'd0, "R1 dir");
        rd(A_OPEN, 32'd0, "R1 open");
        rd(A_DATA, 32'd0, "R1 data");
        rd(A_EVT,  32'd0, "R1 evt");
        rd(A_MASK, 32'd0, "R1 mask");
        rd(A_TRIG, 32'd0, "R1 trig");

        // R11 init sequence
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_MASK, 32'd0);

        // R2 R3 R4: pin 0 push-pull, pin 5 open-drain
        wr(A_DIR, bitof(0) | bitof(5));
        wr(A_OPEN, bitof(5));
        wr(A_DATA, bitof(0));
        chk("R4 oe od low", pin_oe, 32'h0000_0021);
        chk("R2 out", pin_out, 32'h0000_0001);
        wr(A_DATA, bitof(0) | bitof(5));
        chk("R4 oe od release", pin_oe, 32'h0000_0001);
        chk("R4 out od", pin_out, 32'h0000_0001);
        rd(A_OPEN, 32'h0400_0000, "R2 open bit");
        pin_in[7] = 1'b1;
        idle(3);
        rd(A_DATA, bitof(0) | bitof(5) | bitof(7), "R3 data mix");
        wr(A_DATA, bitof(5));
        rd(A_DATA, bitof(5) | bitof(7), "R3 data out0");

        // R5 latency
        wr(A_EVT, 32'hFFFF_FFFF);
        wr(A_MASK, bitof(9));
        pin_in[9] = 1'b1;
        idle(2);
        chk("R5 early", {31'd0, irq}, 32'd0);
        idle(1);
        chk("R5 on time", {31'd0, irq}, 32'd1);
        rd(A_EVT, bitof(9), "R5 evt");

        // R7 write-zero keeps, write-one clears
        wr(A_EVT, 32'd0);
        rd(A_EVT, bitof(9), "R7 zero write");
        wr(A_EVT, bitof(9));
        chk("R7 irq cleared", {31'd0, irq}, 32'd0);
        rd(A_EVT, 32'd0, "R7 cleared");

        // R6 trigger select
        wr(A_TRIG, bitof(12));
        rd(A_TRIG, bitof(12), "R6 trig readback");
        pin_in[12] = 1'b1;
        idle(4);
        rd(A_EVT, 32'd0, "R6 rise ignored");
        pin_in[12] = 1'b0;
        idle(4);
        rd(A_EVT, bitof(12), "R6 fall caught");
        wr(A_EVT, 32'hFFFF_FFFF);
        pin_in[13] = 1'b1;
        idle(4);
        rd(A_EVT, bitof(13), "R6 both rise");
        wr(A_EVT, bitof(13));
        pin_in[13] = 1'b0;
        idle(4);
        rd(A_EVT, bitof(13), "R6 both fall");
        wr(A_EVT, 32'hFFFF_FFFF);

        // R8 edge coincident with clear
        pin_in[14] = 1'b1;
        idle(4);
        rd(A_EVT, bitof(14), "R8 setup");
        pin_in[14] = 1'b0;
        idle(2);
        wr(A_EVT, bitof(14));
        rd(A_EVT, bitof(14), "R8 kept");
        wr(A_EVT, bitof(14));
        rd(A_EVT, 32'd0, "R8 control clear");

        // R9 masked capture, then unmask
        wr(A_MASK, 32'd0);
        pin_in[20] = 1'b1;
        idle(4);
        chk("R9 masked irq", {31'd0, irq}, 32'd0);
        rd(A_EVT, bitof(20), "R9 masked capture");
        wr(A_MASK, bitof(20));
        chk("R9 unmask irq", {31'd0, irq}, 32'd1);
        rd(A_MASK, bitof(20), "R9 mask readback");

        // R11 clear all pending
        pin_in[21] = 1'b1;
        pin_in[22] = 1'b1;
        wr(A_MASK, 32'hFFFF_FFFF);
        idle(4);
        rd(A_EVT, bitof(20) | bitof(21) | bitof(22), "R11 pending");
        wr(A_EVT, 32'hFFFF_FFFF);
        chk("R11 irq", {31'd0, irq}, 32'd0);
        rd(A_EVT, 32'd0, "R11 all cleared");

        // R10 unmapped offsets
        rd(5'h18, 32'd0, "R10 off18");
        rd(5'h1C, 32'd0, "R10 off1c");
        idle(2);
        chk("R10 hold", bus_rdata, 32'd0);

        idle(2);
        finished = 1;
        summary();
        $finish;
    end
endmodule